// File: doc/BRIEF.md
# Indexed Clock-Chip Register Port with Interrupt Flags

This block is the bus-facing front end of a real-time clock and battery-backed RAM device. Software reaches a 128-byte space through two addresses. A write to the even address selects a byte by its 7-bit index. A read or write at the odd address then reaches the selected byte. Most indices land in a RAM that can be inferred as block RAM. A small set of indices lands in dedicated registers:

- control A at 0x0A
- control B at 0x0B
- status C at 0x0C
- status D at 0x0D
- a shutdown byte at 0x0F

The timekeeping and periodic-tick engines sit outside this block. They raise status flags through single-cycle set pulses and report update-in-progress on a level input. They read back A and B through dedicated outputs.

The block merges each raised flag with its enable into a request bit, C[7], and a level interrupt line. Reading C returns its content and then empties it. Writing B re-evaluates the request at once against the flags already pending. One alternate century index is folded onto the primary century byte. Two synchronous resets exist: a power-on reset that loads the documented initial values, and a system reset that only quiets the interrupt machinery and the shutdown byte.

Top module: `rtc_regport`

## Requirements
- R1: A write with bus_addr=0 stores bus_wdata[6:0] as the index, and bit 7 is discarded. A read with bus_addr=0 returns 0xFF.
- R2: A write with bus_addr=1 stores the byte at the current index. A read with bus_addr=1 presents that byte on bus_rdata from the clock edge that accepts the read until the next read.
- R3: Writes to C (0x0C) and D (0x0D) change nothing. D always reads 0x80.
- R4: Writing A (0x0A) stores bits 6:0. Bit 7 of A is the update-in-progress input registered once and cannot be written.
- R5: Reading C returns its value, then C becomes 0x00 and irq drops on the same edge.
- R6: A write to B (bit 6 = periodic enable, bit 5 = alarm enable, bit 4 = update enable) sets C[7] and irq when any pending flag has its new enable set. Otherwise the write clears both C[7] and irq.
- R7: A pulse on set_pf, set_af or set_uf sets C[6], C[5] or C[4] in that order. When the matching enable in B is set, the pulse also sets C[7] and irq. irq is a level that is only ever high while at least one flag is pending.
- R8: After power-on reset, A=0x26, B=0x02, C=0x00, D=0x80, and irq is low.
- R9: System reset clears B bits 6, 5 and 3, clears all of C, and drops irq. The other bits of B and all of A are kept.
- R10: System reset zeroes the shutdown byte at 0x0F unless it holds 0xFE, in which case the byte is kept.
- R11: Any odd-address access while the index is the alternate century index (0x37) reaches the primary century byte (0x32) and rewrites the index to 0x32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset, active high |
| rst | input | 1 | Synchronous system reset, active high |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid after the edge that takes the read |
| set_pf | input | 1 | Periodic flag set pulse |
| set_af | input | 1 | Alarm flag set pulse |
| set_uf | input | 1 | Update-ended flag set pulse |
| uip_in | input | 1 | Update-in-progress level from the timekeeping engine |
| reg_a_o | output | 8 | Current content of control A |
| reg_b_o | output | 8 | Current content of control B |
| irq | output | 1 | Level interrupt request |

## Verification
The flag register and the request bit drive irq through a single register. A wrong flag or enable state therefore shows on irq, or in the next read of C, one edge after the pulse, the B write or the C read that caused it.

A wrong index shows on the very next data-port read. That read returns another byte, or an alias that fails to stick is exposed when the index is reused. Reset faults surface on the first reads of B, C and 0x0F after reset. Each of those values is predicted from the reset rules.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int IDX_W  = 7;
  localparam int BYTE_W = 8;

  localparam logic [IDX_W-1:0] IDX_CTRL_A = 7'h0A;
  localparam logic [IDX_W-1:0] IDX_CTRL_B = 7'h0B;
  localparam logic [IDX_W-1:0] IDX_STAT_C = 7'h0C;
  localparam logic [IDX_W-1:0] IDX_STAT_D = 7'h0D;

  localparam logic [6:0]        POR_A_LOW = 7'h26;
  localparam logic [BYTE_W-1:0] POR_B     = 8'h02;
  localparam logic [BYTE_W-1:0] CONST_D   = 8'h80;
  localparam logic [BYTE_W-1:0] IDX_READ  = 8'hFF;

  // enables cleared by system reset: periodic(6), alarm(5), square wave(3)
  localparam logic [BYTE_W-1:0] B_RST_MASK = 8'h68;

  typedef enum logic [2:0] {
    SRC_HOLD, SRC_RAM
  } rd_src_e;
endpackage

// File: rtl/rtc_index_unit.sv
module rtc_index_unit
  import rtc_regport_pkg::*;
#(
  parameter logic [IDX_W-1:0] PRIM_IDX = 7'h32,
  parameter logic [IDX_W-1:0] ALT_IDX  = 7'h37
) (
  input  logic             clk,
  input  logic             por,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             data_acc,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] idx_eff
);
  logic hit_alt;

  assign hit_alt = (idx_q == ALT_IDX);
  assign idx_eff = hit_alt ? PRIM_IDX : idx_q;

  always_ff @(posedge clk) begin
    if (por) begin
      idx_q <= '0;
    end else if (load) begin
      idx_q <= load_val;
    end else if (data_acc && hit_alt) begin
      idx_q <= PRIM_IDX;
    end
  end
endmodule

// File: rtl/rtc_nvram.sv
module rtc_nvram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    rdata_q <= mem[addr];
  end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regport_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SD_KEEP = 8'hFE
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic              wr_sd,
  input  logic              rd_c,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              set_pf,
  input  logic              set_af,
  input  logic              set_uf,
  input  logic              uip_in,
  output logic [BYTE_W-1:0] a_val,
  output logic [BYTE_W-1:0] b_val,
  output logic [BYTE_W-1:0] c_val,
  output logic [BYTE_W-1:0] sd_val,
  output logic              irq_q
);
  logic [6:0]        a_low;
  logic              uip_q;
  logic [BYTE_W-1:0] b_q;
  logic [2:0]        flags_q;   // {periodic, alarm, update}
  logic [BYTE_W-1:0] sd_q;
  logic [2:0]        flags_n;
  logic              irq_n;
  logic [2:0]        en_eff;
  logic [2:0]        set_vec;

  assign set_vec = {set_pf, set_af, set_uf};

  always_comb begin
    flags_n = flags_q;
    irq_n   = irq_q;
    en_eff  = b_q[6:4];
    if (rd_c) begin
      flags_n = '0;
      irq_n   = 1'b0;
    end
    if (wr_b) begin
      en_eff = wdata[6:4];
      irq_n  = |(wdata[6:4] & flags_q);
    end
    flags_n = flags_n | set_vec;
    if (|(set_vec & en_eff)) begin
      irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      a_low   <= POR_A_LOW;
      uip_q   <= 1'b0;
      b_q     <= POR_B;
      flags_q <= '0;
      irq_q   <= 1'b0;
      sd_q    <= '0;
    end else if (rst) begin
      uip_q   <= uip_in;
      b_q     <= b_q & ~B_RST_MASK;
      flags_q <= '0;
      irq_q   <= 1'b0;
      if (sd_q != SD_KEEP) begin
        sd_q <= '0;
      end
    end else begin
      uip_q   <= uip_in;
      flags_q <= flags_n;
      irq_q   <= irq_n;
      if (wr_a) begin
        a_low <= wdata[6:0];
      end
      if (wr_b) begin
        b_q <= wdata;
      end
      if (wr_sd) begin
        sd_q <= wdata;
      end
    end
  end

  assign a_val  = {uip_q, a_low};
  assign b_val  = b_q;
  assign c_val  = {irq_q, flags_q, 4'b0000};
  assign sd_val = sd_q;
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
#(
  parameter logic [IDX_W-1:0]  CENTURY_IDX     = 7'h32,
  parameter logic [IDX_W-1:0]  CENTURY_ALT_IDX = 7'h37,
  parameter logic [IDX_W-1:0]  SHUTDOWN_IDX    = 7'h0F,
  parameter logic [BYTE_W-1:0] SHUTDOWN_KEEP   = 8'hFE
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              set_pf,
  input  logic              set_af,
  input  logic              set_uf,
  input  logic              uip_in,
  output logic [BYTE_W-1:0] reg_a_o,
  output logic [BYTE_W-1:0] reg_b_o,
  output logic              irq
);
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  idx_eff;
  logic [BYTE_W-1:0] c_val;
  logic [BYTE_W-1:0] sd_val;
  logic [BYTE_W-1:0] ram_q;
  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] hold_n;
  rd_src_e           src_q;
  rd_src_e           src_n;
  logic              data_wr;
  logic              data_rd;
  logic              is_a;
  logic              is_b;
  logic              is_c;
  logic              is_d;
  logic              is_sd;
  logic              is_ctrl;

  assign data_wr = bus_wr && bus_addr;
  assign data_rd = bus_rd && bus_addr;

  assign is_a    = (idx_eff == IDX_CTRL_A);
  assign is_b    = (idx_eff == IDX_CTRL_B);
  assign is_c    = (idx_eff == IDX_STAT_C);
  assign is_d    = (idx_eff == IDX_STAT_D);
  assign is_sd   = (idx_eff == SHUTDOWN_IDX);
  assign is_ctrl = is_a | is_b | is_c | is_d | is_sd;

  rtc_index_unit #(
    .PRIM_IDX (CENTURY_IDX),
    .ALT_IDX  (CENTURY_ALT_IDX)
  ) u_index (
    .clk      (clk),
    .por      (por),
    .load     (bus_wr && !bus_addr),
    .load_val (bus_wdata[IDX_W-1:0]),
    .data_acc (data_wr || data_rd),
    .idx_q    (idx_q),
    .idx_eff  (idx_eff)
  );

  rtc_nvram #(
    .AW (IDX_W),
    .DW (BYTE_W)
  ) u_ram (
    .clk     (clk),
    .we      (data_wr && !is_ctrl),
    .addr    (idx_eff),
    .wdata   (bus_wdata),
    .rdata_q (ram_q)
  );

  rtc_ctrl_regs #(
    .SD_KEEP (SHUTDOWN_KEEP)
  ) u_ctrl (
    .clk    (clk),
    .por    (por),
    .rst    (rst),
    .wr_a   (data_wr && is_a),
    .wr_b   (data_wr && is_b),
    .wr_sd  (data_wr && is_sd),
    .rd_c   (data_rd && is_c),
    .wdata  (bus_wdata),
    .set_pf (set_pf),
    .set_af (set_af),
    .set_uf (set_uf),
    .uip_in (uip_in),
    .a_val  (reg_a_o),
    .b_val  (reg_b_o),
    .c_val  (c_val),
    .sd_val (sd_val),
    .irq_q  (irq)
  );

  // read source selection, captured with the read strobe
  always_comb begin
    src_n  = SRC_HOLD;
    hold_n = IDX_READ;
    if (bus_addr) begin
      unique case (1'b1)
        is_a:    hold_n = reg_a_o;
        is_b:    hold_n = reg_b_o;
        is_c:    hold_n = c_val;
        is_d:    hold_n = CONST_D;
        is_sd:   hold_n = sd_val;
        default: src_n  = SRC_RAM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      src_q  <= SRC_HOLD;
      hold_q <= '0;
    end else if (bus_rd) begin
      src_q  <= src_n;
      hold_q <= hold_n;
    end
  end

  assign bus_rdata = (src_q == SRC_RAM) ? ram_q : hold_q;
endmodule

module rtc_regport_chk
  import rtc_regport_pkg::*;
(
  input logic              clk,
  input logic              por,
  input logic              rst,
  input logic              bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              set_pf,
  input logic              set_af,
  input logic              set_uf,
  input logic [BYTE_W-1:0] reg_a_o,
  input logic              irq,
  input logic [IDX_W-1:0]  idx_q,
  input logic [BYTE_W-1:0] c_val
);
  p_index_low7_r1: assert property (@(posedge clk) disable iff (por || rst)
    (bus_wr && !bus_addr) |=> (idx_q == $past(bus_wdata[IDX_W-1:0])));

  p_even_read_ff_r1: assert property (@(posedge clk) disable iff (por || rst)
    (bus_rd && !bus_addr) |=> (bus_rdata == 8'hFF));

  p_a_write_low_r4: assert property (@(posedge clk) disable iff (por || rst)
    (bus_wr && bus_addr && idx_q == IDX_CTRL_A) |=> (reg_a_o[6:0] == $past(bus_wdata[6:0])));

  p_c_read_clears_r5: assert property (@(posedge clk) disable iff (por || rst)
    (bus_rd && bus_addr && idx_q == IDX_STAT_C && !(set_pf || set_af || set_uf))
    |=> (!irq && c_val == 8'h00));

  p_b_write_raises_r6: assert property (@(posedge clk) disable iff (por || rst)
    (bus_wr && bus_addr && idx_q == IDX_CTRL_B && (|(bus_wdata[6:4] & c_val[6:4])))
    |=> irq);

  p_irq_has_flag_r7: assert property (@(posedge clk) disable iff (por || rst)
    irq |-> (c_val[6:4] != 3'b000));

  p_sys_reset_quiet_r9: assert property (@(posedge clk) disable iff (por)
    rst |=> (!irq && c_val == 8'h00));
endmodule

bind rtc_regport rtc_regport_chk u_chk (
  .clk       (clk),
  .por       (por),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .set_pf    (set_pf),
  .set_af    (set_af),
  .set_uf    (set_uf),
  .reg_a_o   (reg_a_o),
  .irq       (irq),
  .idx_q     (idx_q),
  .c_val     (c_val)
);

// File: tb/rtc_regport_tb.sv
module rtc_regport_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       rst = 1'b0;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       set_pf = 1'b0;
  logic       set_af = 1'b0;
  logic       set_uf = 1'b0;
  logic       uip_in = 1'b0;
  logic [7:0] reg_a_o;
  logic [7:0] reg_b_o;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regport u_dut (
    .clk       (clk),
    .por       (por),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .set_pf    (set_pf),
    .set_af    (set_af),
    .set_uf    (set_uf),
    .uip_in    (uip_in),
    .reg_a_o   (reg_a_o),
    .reg_b_o   (reg_b_o),
    .irq       (irq)
  );

  // vector: {kind(1: 0 write, 1 read-check), addr(1), data(8), expected(8), req(4)}
  localparam int NV = 22;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h8A, 8'h00, 4'd1},  // R1 bit 7 dropped -> index 0x0A
    {1'b1, 1'b1, 8'h00, 8'h26, 4'd8},  // R8 A
    {1'b0, 1'b0, 8'h0B, 8'h00, 4'd8},
    {1'b1, 1'b1, 8'h00, 8'h02, 4'd8},  // R8 B
    {1'b0, 1'b0, 8'h0C, 8'h00, 4'd8},
    {1'b1, 1'b1, 8'h00, 8'h00, 4'd8},  // R8 C
    {1'b0, 1'b0, 8'h0D, 8'h00, 4'd3},
    {1'b1, 1'b1, 8'h00, 8'h80, 4'd3},  // R8 / R3 D
    {1'b0, 1'b1, 8'h00, 8'h00, 4'd3},  // R3 write D
    {1'b1, 1'b1, 8'h00, 8'h80, 4'd3},
    {1'b0, 1'b0, 8'h20, 8'h00, 4'd2},
    {1'b0, 1'b1, 8'h5A, 8'h00, 4'd2},
    {1'b0, 1'b0, 8'hFF, 8'h00, 4'd2},  // index 0x7F
    {1'b0, 1'b1, 8'hC3, 8'h00, 4'd2},
    {1'b1, 1'b1, 8'h00, 8'hC3, 4'd2},  // R2
    {1'b0, 1'b0, 8'h20, 8'h00, 4'd2},
    {1'b1, 1'b1, 8'h00, 8'h5A, 4'd2},  // R2
    {1'b1, 1'b0, 8'h00, 8'hFF, 4'd1},  // R1 even read
    {1'b0, 1'b0, 8'h37, 8'h00, 4'd11},
    {1'b0, 1'b1, 8'h19, 8'h00, 4'd11}, // R11 lands on 0x32
    {1'b0, 1'b0, 8'h32, 8'h00, 4'd11},
    {1'b1, 1'b1, 8'h00, 8'h19, 4'd11}  // R11
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_idx(input logic [7:0] i, output logic [7:0] d);
    bwrite(1'b0, i);
    bread(1'b1, d);
  endtask

  task automatic wr_idx(input logic [7:0] i, input logic [7:0] v);
    bwrite(1'b0, i);
    bwrite(1'b1, v);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) set_pf = 1'b1;
    if (which == 1) set_af = 1'b1;
    if (which == 2) set_uf = 1'b1;
    @(negedge clk);
    set_pf = 1'b0; set_af = 1'b0; set_uf = 1'b0;
  endtask

  task automatic sys_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 10000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0x00 expected=0x01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    por = 1'b0;
    chk("R8 irq after power-on", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) begin
        bread(VEC[i][20], d);
        chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), d, VEC[i][11:4]);
      end else begin
        bwrite(VEC[i][20], VEC[i][19:12]);
      end
    end

    // R4: update-in-progress bit not writable, follows input
    wr_idx(8'h0A, 8'hFF);
    rd_idx(8'h0A, d);
    chk("R4 A write keeps uip=0", d, 8'h7F);
    uip_in = 1'b1;
    wr_idx(8'h0A, 8'h26);
    rd_idx(8'h0A, d);
    chk("R4 A with uip=1", d, 8'hA6);
    uip_in = 1'b0;

    // R7 flag without enable, R3 write to C ignored
    wr_idx(8'h0B, 8'h02);
    pulse(0);
    chk("R7 no irq without enable", {7'd0, irq}, 8'h00);
    wr_idx(8'h0C, 8'hFF);
    rd_idx(8'h0C, d);
    chk("R3 C ignores write / R7 pf flag", d, 8'h40);
    rd_idx(8'h0C, d);
    chk("R5 C empty after read", d, 8'h00);

    // R7 flag with enable, R5 read clears
    wr_idx(8'h0B, 8'h42);
    chk("R6 no pending flag -> irq low", {7'd0, irq}, 8'h00);
    pulse(0);
    chk("R7 enabled pf raises irq", {7'd0, irq}, 8'h01);
    rd_idx(8'h0C, d);
    chk("R5 C read value", d, 8'hC0);
    chk("R5 irq dropped by C read", {7'd0, irq}, 8'h00);

    // R6 enable written while flag pending
    wr_idx(8'h0B, 8'h02);
    pulse(2);
    chk("R7 uf without enable", {7'd0, irq}, 8'h00);
    wr_idx(8'h0B, 8'h12);
    chk("R6 enable on pending uf raises irq", {7'd0, irq}, 8'h01);
    wr_idx(8'h0B, 8'h02);
    chk("R6 enable removed drops irq", {7'd0, irq}, 8'h00);
    rd_idx(8'h0C, d);
    chk("R6 request bit cleared by B write", d, 8'h10);

    // R9 system reset
    wr_idx(8'h0B, 8'h7E);
    pulse(1);
    chk("R7 enabled af raises irq", {7'd0, irq}, 8'h01);
    sys_reset();
    chk("R9 irq dropped by reset", {7'd0, irq}, 8'h00);
    rd_idx(8'h0B, d);
    chk("R9 B after reset", d, 8'h16);
    rd_idx(8'h0C, d);
    chk("R9 C after reset", d, 8'h00);
    rd_idx(8'h0A, d);
    chk("R9 A kept", d, 8'h26);

    // R10 shutdown byte
    wr_idx(8'h0F, 8'hFE);
    sys_reset();
    rd_idx(8'h0F, d);
    chk("R10 0xFE kept", d, 8'hFE);
    wr_idx(8'h0F, 8'h55);
    sys_reset();
    rd_idx(8'h0F, d);
    chk("R10 other value zeroed", d, 8'h00);

    // R11 alias on read rewrites the index
    bwrite(1'b0, 8'h37);
    bread(1'b1, d);
    chk("R11 alternate read", d, 8'h19);
    bwrite(1'b1, 8'h77);
    bwrite(1'b0, 8'h32);
    bread(1'b1, d);
    chk("R11 index stays primary", d, 8'h77);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule